// File: doc/BRIEF.md
# Three-Phase Sensor Scan Sequencer

This block walks a thin-film sensor array through its sensors one at a time, using a global reset line and three ordered phase signals. The three phases are precharge, drive and reset of the bootstrap stage, in that order. When scanning starts, the global reset line is raised once for one phase duration. After that, the block works in one of two modes, sampled from `mode_sel` when scanning begins.

In driven mode, a circulating one-hot ring produces the three phases. Each phase lasts a programmable number of system clock cycles. Each phase is also gated onto a free-running carrier, so that it leaves the block as an AC burst for the coupling interface. In follow mode, the block produces no phases of its own. It takes in three externally generated, already digitized phase signals. It synchronizes them, detects their rising edges, checks that they arrive in order, and emits a one-cycle pulse per accepted edge.

In both modes, each completed precharge-drive-reset cycle advances a sensor index and raises a one-cycle advance strobe for the acquisition controller. The index wraps at a programmable array size. The block has no data stream. Every pin is a plain control or status level or pulse, with no valid/ready handshake and no back-pressure. The acquisition side must take the advance strobe in the cycle it is high.

Top module: `scan_sequencer`

## Requirements
- R1: While `rst_n` is low, all outputs are 0: `grst_o`, `phase_o`, both AC outputs, `edge_o`, `adv_o`, `order_err_o`, and `sensor_idx_o` is 0.
- R2: At most one of `grst_o`, `phase_o[0]` (precharge), `phase_o[1]` (drive) and `phase_o[2]` (reset) is high in any cycle.
- R3: In driven mode, the first clock edge with `scan_en` high starts a run. `grst_o` is high for L cycles, where L is `phase_len`. Then `phase_o[0]`, `phase_o[1]` and `phase_o[2]` are each high for L cycles, and this triple repeats. `grst_o` is not raised again during the run.
- R4: The carrier has a period of 2*CAR_HALF clock cycles, with a 50% duty cycle. `phase_ac_o[k]` and `grst_ac_o` equal their envelope ANDed with the carrier, so they are never high while the envelope is low.
- R5: In follow mode, `grst_o` is issued once as in R3, and `phase_o` stays 0. After `grst_o` ends, a rising edge on `ext_phase[k]` yields a one-cycle pulse on `edge_o[k]`. That pulse is visible in the third cycle after the input changes, because of a two-flop synchronizer. This happens only when the edge is the expected one in the order bit 0, bit 1, bit 2, bit 0, and so on.
- R6: In follow mode, a rising edge other than the expected one, or two rising edges in the same cycle, sets `order_err_o` and yields no `edge_o` pulse and no advance. `order_err_o` stays set while `scan_en` stays high. After a single out-of-order edge on bit k, the next edge expected is bit k+1 (modulo 3). After simultaneous edges, the expected edge is unchanged.
- R7: `adv_o` pulses for one cycle at each completed cycle: at the end of `phase_o[2]` in driven mode, or together with an accepted `edge_o[2]` in follow mode.
- R8: `sensor_idx_o` increments in the same cycle as `adv_o`. After reaching `array_size`-1 it returns to 0. An `array_size` of 0 acts as 2^IDX_W.
- R9: `mode_sel` is sampled only when a run starts. Changing it during a run has no effect.
- R10: When `scan_en` is sampled low, the block returns to idle on the next edge. All outputs go to 0, and the index and the error flag are cleared.
- R11: A `phase_len` of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_en | input | 1 | Run request; a low level returns the block to idle |
| mode_sel | input | 1 | 0 = driven mode, 1 = follow mode (sampled at run start) |
| phase_len | input | CNT_W | Duration of the global reset and of each phase, in cycles |
| array_size | input | IDX_W | Number of sensors; the index wraps after array_size-1 |
| ext_phase | input | 3 | External phases in follow mode: bit 0 precharge, bit 1 drive, bit 2 reset |
| grst_o | output | 1 | Global reset envelope |
| phase_o | output | 3 | Driven phase envelopes, bit order as in ext_phase |
| grst_ac_o | output | 1 | Global reset gated onto the carrier |
| phase_ac_o | output | 3 | Phase envelopes gated onto the carrier |
| edge_o | output | 3 | One-cycle pulse per accepted external phase edge |
| adv_o | output | 1 | One-cycle sensor advance strobe |
| sensor_idx_o | output | IDX_W | Current sensor index |
| order_err_o | output | 1 | Sticky phase-order error flag |

## Verification
Two behaviours are hard to reach from the ports. The first is the index wrap at the full counter width, which requires hundreds of complete cycles. The bench reaches it by running driven mode with a phase length of 0, so each cycle takes three clocks, and an array size of 0. It then compares the number of observed advance pulses and the final index with values worked out by hand. The second is the order-error resynchronization, which needs a follow-mode input pattern that no well-behaved external phase generator would produce. The bench drives an out-of-order drive edge, then a reset edge, then two simultaneous rising edges, and checks the pulse outputs and the error flag after each one.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef enum logic {
    MODE_DRIVEN = 1'b0,
    MODE_FOLLOW = 1'b1
  } scan_mode_e;

  // advance a one-hot phase vector: precharge -> drive -> reset -> precharge
  function automatic logic [2:0] next_phase(input logic [2:0] v);
    return {v[1:0], v[2]};
  endfunction

  function automatic logic is_onehot3(input logic [2:0] v);
    return (v != 3'b000) && ((v & (v - 3'b001)) == 3'b000);
  endfunction
endpackage

// File: rtl/seq_carrier_gen.sv
module seq_carrier_gen #(
  parameter int CAR_HALF = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic carrier_o
);
  localparam int CW = (CAR_HALF < 2) ? 1 : $clog2(CAR_HALF);
  localparam logic [CW-1:0] LAST = CW'(CAR_HALF - 1);

  logic [CW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q     <= '0;
      carrier_o <= 1'b0;
    end else if (div_q == LAST) begin
      div_q     <= '0;
      carrier_o <= ~carrier_o;
    end else begin
      div_q <= div_q + CW'(1);
    end
  end
endmodule

// File: rtl/seq_phase_ring.sv
module seq_phase_ring
  import scan_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_en,
  input  scan_mode_e       mode_i,
  input  logic [CNT_W-1:0] phase_len,
  output logic             grst_o,
  output logic [2:0]       phase_o,
  output logic             armed_o,
  output logic             cyc_done_o
);
  // ring_q[0] = global reset slot, ring_q[3:1] = precharge, drive, reset
  logic [3:0]       ring_q;
  logic [CNT_W-1:0] dwell_q;
  logic             run_q;
  scan_mode_e       mode_q;
  logic             slot_end;

  assign slot_end = ({1'b0, dwell_q} + (CNT_W+1)'(1)) >= {1'b0, phase_len};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      mode_q  <= MODE_DRIVEN;
      ring_q  <= '0;
      dwell_q <= '0;
    end else if (!scan_en) begin
      run_q   <= 1'b0;
      ring_q  <= '0;
      dwell_q <= '0;
    end else if (!run_q) begin
      run_q   <= 1'b1;
      mode_q  <= mode_i;
      ring_q  <= 4'b0001;
      dwell_q <= '0;
    end else if (ring_q != 4'b0000) begin
      if (slot_end) begin
        dwell_q <= '0;
        if (ring_q[0])
          ring_q <= (mode_q == MODE_FOLLOW) ? 4'b0000 : 4'b0010;
        else if (ring_q[3])
          ring_q <= 4'b0010;
        else
          ring_q <= {ring_q[2:0], 1'b0};
      end else begin
        dwell_q <= dwell_q + CNT_W'(1);
      end
    end
  end

  assign grst_o     = ring_q[0];
  assign phase_o    = ring_q[3:1];
  assign armed_o    = run_q && scan_en && (ring_q == 4'b0000) && (mode_q == MODE_FOLLOW);
  assign cyc_done_o = run_q && scan_en && ring_q[3] && slot_end;
endmodule

// File: rtl/seq_edge_tracker.sv
module seq_edge_tracker
  import scan_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear_i,
  input  logic       enable_i,
  input  logic [2:0] ext_i,
  output logic [2:0] edge_o,
  output logic       err_o,
  output logic       cyc_done_o
);
  logic [2:0] sync1_q, sync2_q, hist_q;
  logic [2:0] want_q;
  logic [2:0] rise;
  logic       in_order;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      hist_q  <= '0;
    end else begin
      sync1_q <= ext_i;
      sync2_q <= sync1_q;
      hist_q  <= sync2_q;
    end
  end

  assign rise     = sync2_q & ~hist_q;
  assign in_order = enable_i && (rise == want_q);

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      want_q <= 3'b001;
      err_o  <= 1'b0;
      edge_o <= '0;
    end else if (enable_i) begin
      edge_o <= in_order ? rise : 3'b000;
      if (in_order) begin
        want_q <= next_phase(want_q);
      end else if (rise != 3'b000) begin
        err_o <= 1'b1;
        if (is_onehot3(rise)) want_q <= next_phase(rise);
      end
    end else begin
      edge_o <= '0;
    end
  end

  assign cyc_done_o = in_order && want_q[2];
endmodule

// File: rtl/seq_index_ctr.sv
module seq_index_ctr #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic [IDX_W-1:0] array_size,
  output logic [IDX_W-1:0] idx_o,
  output logic             adv_o
);
  logic [IDX_W-1:0] last_idx;
  assign last_idx = array_size - IDX_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      idx_o <= '0;
      adv_o <= 1'b0;
    end else begin
      adv_o <= step_i;
      if (step_i) idx_o <= (idx_o == last_idx) ? '0 : idx_o + IDX_W'(1);
    end
  end
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import scan_seq_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int IDX_W    = 8,
  parameter int CAR_HALF = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_en,
  input  logic             mode_sel,
  input  logic [CNT_W-1:0] phase_len,
  input  logic [IDX_W-1:0] array_size,
  input  logic [2:0]       ext_phase,
  output logic             grst_o,
  output logic [2:0]       phase_o,
  output logic             grst_ac_o,
  output logic [2:0]       phase_ac_o,
  output logic [2:0]       edge_o,
  output logic             adv_o,
  output logic [IDX_W-1:0] sensor_idx_o,
  output logic             order_err_o
);
  scan_mode_e mode_e;
  logic carrier, armed, ring_done, trk_done, clear;

  assign mode_e = scan_mode_e'(mode_sel);
  assign clear  = !scan_en;

  seq_carrier_gen #(.CAR_HALF(CAR_HALF)) u_car (
    .clk(clk), .rst_n(rst_n), .carrier_o(carrier)
  );

  seq_phase_ring #(.CNT_W(CNT_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .mode_i(mode_e),
    .phase_len(phase_len), .grst_o(grst_o), .phase_o(phase_o),
    .armed_o(armed), .cyc_done_o(ring_done)
  );

  seq_edge_tracker u_trk (
    .clk(clk), .rst_n(rst_n), .clear_i(clear), .enable_i(armed),
    .ext_i(ext_phase), .edge_o(edge_o), .err_o(order_err_o),
    .cyc_done_o(trk_done)
  );

  seq_index_ctr #(.IDX_W(IDX_W)) u_idx (
    .clk(clk), .rst_n(rst_n), .clear_i(clear), .step_i(ring_done | trk_done),
    .array_size(array_size), .idx_o(sensor_idx_o), .adv_o(adv_o)
  );

  assign grst_ac_o  = grst_o & carrier;
  assign phase_ac_o = phase_o & {3{carrier}};
endmodule

// File: rtl/scan_sequencer_chk.sv
module scan_sequencer_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scan_en,
  input logic             grst_o,
  input logic [2:0]       phase_o,
  input logic             grst_ac_o,
  input logic [2:0]       phase_ac_o,
  input logic [2:0]       edge_o,
  input logic             adv_o,
  input logic [IDX_W-1:0] sensor_idx_o,
  input logic             order_err_o
);
  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grst_o, phase_o}));

  p_pre_to_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(scan_en) && $fell(phase_o[0])) |-> phase_o[1]);
  p_drive_to_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(scan_en) && $fell(phase_o[1])) |-> phase_o[2]);
  p_reset_to_pre_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(scan_en) && $fell(phase_o[2])) |-> phase_o[0]);
  p_grst_then_pre_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(scan_en) && $fell(grst_o)) |-> (phase_o[2:1] == 2'b00));

  p_ac_in_envelope_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_ac_o & ~phase_o) == 3'b000) && (!grst_ac_o || grst_o));

  p_edge_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(edge_o));

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (order_err_o && scan_en) |=> order_err_o);

  p_adv_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    adv_o |=> !adv_o);

  p_idx_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    adv_o |-> (sensor_idx_o == IDX_W'($past(sensor_idx_o) + IDX_W'(1))) || (sensor_idx_o == '0));
endmodule

bind scan_sequencer scan_sequencer_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .grst_o(grst_o),
  .phase_o(phase_o), .grst_ac_o(grst_ac_o), .phase_ac_o(phase_ac_o),
  .edge_o(edge_o), .adv_o(adv_o), .sensor_idx_o(sensor_idx_o),
  .order_err_o(order_err_o)
);

// File: tb/scan_sequencer_test.sv
module scan_sequencer_test;
  localparam int CNT_W = 16;
  localparam int IDX_W = 8;
  localparam int CAR_HALF = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scan_en = 1'b0;
  logic mode_sel = 1'b0;
  logic [CNT_W-1:0] phase_len = '0;
  logic [IDX_W-1:0] array_size = '0;
  logic [2:0] ext_phase = '0;
  logic grst_o, grst_ac_o, adv_o, order_err_o;
  logic [2:0] phase_o, phase_ac_o, edge_o;
  logic [IDX_W-1:0] sensor_idx_o;

  int checks = 0;
  int errors = 0;
  int adv_seen = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  scan_sequencer #(.CNT_W(CNT_W), .IDX_W(IDX_W), .CAR_HALF(CAR_HALF)) uut (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .mode_sel(mode_sel),
    .phase_len(phase_len), .array_size(array_size), .ext_phase(ext_phase),
    .grst_o(grst_o), .phase_o(phase_o), .grst_ac_o(grst_ac_o),
    .phase_ac_o(phase_ac_o), .edge_o(edge_o), .adv_o(adv_o),
    .sensor_idx_o(sensor_idx_o), .order_err_o(order_err_o)
  );

  always @(negedge clk) if (adv_o) adv_seen <= adv_seen + 1;

  // driven-mode vectors, L=4: cycle offset after scan_en and {adv,grst,reset,drive,precharge}
  localparam int NV = 11;
  localparam int KTAB [NV] = '{1, 4, 5, 8, 9, 12, 13, 16, 17, 18, 29};
  localparam logic [4:0] ETAB [NV] = '{5'b01000, 5'b01000, 5'b00001, 5'b00001, 5'b00010,
                                       5'b00010, 5'b00100, 5'b00100, 5'b10001, 5'b00001,
                                       5'b10001};

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // follow-mode single phase pulse on ext bit b; checks pulse outputs
  task automatic pulse_ext(input int b, input logic [2:0] exp_edge, input logic exp_adv,
                           input string tag);
    ext_phase[b] = 1'b1;
    step(3);
    chk({tag, " edge_o"}, 32'(edge_o), 32'(exp_edge));
    chk({tag, " adv_o"}, 32'(adv_o), 32'(exp_adv));
    chk({tag, " R5 phase_o quiet"}, 32'(phase_o), 32'd0);
    step(1);
    chk({tag, " edge_o one cycle"}, 32'(edge_o), 32'd0);
    ext_phase[b] = 1'b0;
    step(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int pos, hi, stray, base;
    // R1 reset state
    scan_en = 1'b1;
    step(3);
    chk("R1 outputs in reset", {grst_o, phase_o, grst_ac_o, phase_ac_o, edge_o, adv_o, order_err_o},
        32'd0);
    chk("R1 index in reset", 32'(sensor_idx_o), 32'd0);
    scan_en = 1'b0;
    rst_n = 1'b1;
    step(2);

    // R3 / R7 / R2: driven-mode vector walk
    phase_len = 16'd4;
    array_size = 8'd8;
    mode_sel = 1'b0;
    scan_en = 1'b1;
    pos = 0;
    for (int i = 0; i < NV; i++) begin
      step(KTAB[i] - pos);
      pos = KTAB[i];
      chk($sformatf("R3/R7 driven vector k=%0d", KTAB[i]), 32'({adv_o, grst_o, phase_o}),
          32'(ETAB[i]));
    end
    chk("R8 index after two cycles", 32'(sensor_idx_o), 32'd2);

    // R10 stop
    scan_en = 1'b0;
    step(1);
    chk("R10 idle outputs", {grst_o, phase_o, adv_o, order_err_o}, 32'd0);
    chk("R10 index cleared", 32'(sensor_idx_o), 32'd0);

    // R4 carrier gating on grst and precharge
    phase_len = 16'd40;
    scan_en = 1'b1;
    step(10);
    hi = 0; stray = 0;
    for (int c = 0; c < 2 * CAR_HALF; c++) begin
      if (grst_ac_o) hi++;
      if (phase_ac_o != 3'b000) stray++;
      step(1);
    end
    chk("R4 grst carrier duty", 32'(hi), 32'(CAR_HALF));
    chk("R4 no phase AC during grst", 32'(stray), 32'd0);
    step(40);
    hi = 0; stray = 0;
    for (int c = 0; c < 2 * CAR_HALF; c++) begin
      if (phase_ac_o[0]) hi++;
      if (phase_ac_o[2:1] != 2'b00 || grst_ac_o) stray++;
      step(1);
    end
    chk("R4 precharge carrier duty", 32'(hi), 32'(CAR_HALF));
    chk("R4 other AC outputs quiet", 32'(stray), 32'd0);

    // R9 mode change mid-run ignored
    mode_sel = 1'b1;
    step(100);
    chk("R9 driven phases continue", 32'(phase_o != 3'b000), 32'd1);
    scan_en = 1'b0;
    step(1);
    chk("R10 idle after driven run", 32'({grst_o, phase_o}), 32'd0);

    // R5 follow mode
    phase_len = 16'd2;
    array_size = 8'd3;
    mode_sel = 1'b1;
    scan_en = 1'b1;
    step(1);
    chk("R5 grst in follow mode", 32'(grst_o), 32'd1);
    step(2);
    chk("R5 grst ends", 32'(grst_o), 32'd0);
    for (int cyc = 1; cyc <= 3; cyc++) begin
      pulse_ext(0, 3'b001, 1'b0, "R5 precharge");
      pulse_ext(1, 3'b010, 1'b0, "R5 drive");
      pulse_ext(2, 3'b100, 1'b1, "R7 reset edge advances");
      chk($sformatf("R8 follow index cycle %0d", cyc), 32'(sensor_idx_o), 32'(cyc % 3));
    end
    chk("R6 no error on ordered edges", 32'(order_err_o), 32'd0);

    // R6 order errors
    pulse_ext(1, 3'b000, 1'b0, "R6 out-of-order drive");
    chk("R6 error set", 32'(order_err_o), 32'd1);
    pulse_ext(2, 3'b100, 1'b1, "R6 resync on reset edge");
    chk("R6 error sticky", 32'(order_err_o), 32'd1);
    ext_phase = 3'b011;
    step(3);
    chk("R6 simultaneous edges no pulse", 32'(edge_o), 32'd0);
    ext_phase = 3'b000;
    step(4);
    pulse_ext(0, 3'b001, 1'b0, "R6 expectation kept after simultaneous");
    chk("R6 error still set", 32'(order_err_o), 32'd1);
    scan_en = 1'b0;
    step(1);
    chk("R10 error cleared", 32'(order_err_o), 32'd0);

    // R11 zero length, R8 wrap at 2^IDX_W
    mode_sel = 1'b0;
    phase_len = 16'd0;
    array_size = 8'd0;
    step(2);
    base = adv_seen;
    scan_en = 1'b1;
    step(800);
    #1;
    chk("R11 advances with zero length", 32'(adv_seen - base), 32'd266);
    chk("R8 full-width wrap index", 32'(sensor_idx_o), 32'd10);
    scan_en = 1'b0;
    step(2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule